// File: doc/BRIEF.md
# SPI Receive Channel with Automatic CRC Check

This block is the receive half of a serial peripheral port. It samples the serial data line on each rising edge of the serial clock while the select line is low. The clock idles high and data is captured on the second edge of each bit. Eight bits, most significant first, make one word. A completed word is placed in a data register and raises a receive-not-empty flag. In DMA mode that flag also drives a request line toward a DMA controller. A read of the data register, either over the register port or by a DMA acknowledge, clears the flag.

When DMA mode and CRC checking are both enabled, software programs a data-word count. The block keeps a running CRC-8 over that many words. It then takes the next word as the CRC word on its own, with no command from software. That word is delivered like any other word. If it differs from the computed value, a sticky error flag is set. The running value and the word count then restart for the next frame.

The serial inputs are brought into the system clock domain through a synchronizer. The serial clock must therefore stay in each level for several system clock cycles.

Top module: `spi_rx_crc`

## Requirements
- R1: While CTRL bit 0 (enable) is 1 and `ss_n` is low, one bit of `mosi` is taken on each rising edge of `sclk`, most significant bit first. Eight bits form a word. While `ss_n` is high or enable is 0, a partly received word is discarded.
- R2: A completed word is loaded into the data register (address 0) and sets receive-not-empty (`rxne`, status bit 0 at address 1).
- R3: A read of address 0 with `reg_rd`, or `dma_ack` while `dma_req` is high, clears `rxne`. If a word completes in the same cycle, the new word is loaded and `rxne` stays 1.
- R4: `dma_req` is high exactly while `rxne` is 1 and CTRL bit 1 (DMA mode) is 1. `dma_data` shows the data register.
- R5: A word that completes while `rxne` is 1 and no read happens sets overrun (`ovr`, status bit 1) and leaves the earlier word in the data register. Writing status with bit 1 equal to 0 clears `ovr`.
- R6: With enable, DMA mode and CTRL bit 2 (CRC) all set, the word that follows COUNT (address 4) data words is taken as the CRC word. It is loaded, sets `rxne` and requests DMA like a data word.
- R7: The CRC is CRC-8, shifted most significant bit first. The running value starts at 0. It is updated over data words only, never over the CRC word. The polynomial register is at address 2 and resets to 0x07.
- R8: A CRC word that differs from the running CRC sets `crc_err` (status bit 2). The flag stays set until software writes status with bit 2 equal to 0.
- R9: After the CRC word, the running CRC and the word count return to 0, so the next frame is checked on its own.
- R10: With CRC or DMA mode off, every word is data and `crc_err` is never set.
- R11: After reset, `rxne`, `ovr`, `crc_err` and `dma_req` are 0, CTRL (address 3) reads 0 and the polynomial reads 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sclk | input | 1 | serial clock, idles high |
| mosi | input | 1 | serial data in |
| ss_n | input | 1 | active-low select |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data (combinational) |
| dma_req | output | 1 | DMA receive request |
| dma_ack | input | 1 | DMA read of the data register |
| dma_data | output | 8 | data register toward DMA |
| rxne | output | 1 | receive-not-empty flag |
| ovr | output | 1 | overrun flag |
| crc_err | output | 1 | CRC mismatch flag |

## Verification
The bench sends frames whose CRC word is correct and frames whose CRC word is corrupted. It covers two polynomials and runs frames back to back. A design that folded the CRC word into the running value, or failed to restart it after a frame, would flag good frames. A design with a non-sticky error would lose the flag on the next good frame. The bench also aborts a word halfway by raising the select line, lets a second word arrive unread to provoke overrun, and runs DMA mode without CRC. A design that kept stale bits, overwrote the held word, or treated a data word as a CRC word would return a wrong byte or raise a false error.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int WORD_W = 8;

    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_STAT = 3'd1;
    localparam logic [2:0] ADR_POLY = 3'd2;
    localparam logic [2:0] ADR_CTRL = 3'd3;
    localparam logic [2:0] ADR_CNT  = 3'd4;

    localparam int CTL_EN  = 0;
    localparam int CTL_DMA = 1;
    localparam int CTL_CRC = 2;

    localparam int ST_RXNE = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_CERR = 2;

    localparam logic [WORD_W-1:0] POLY_RST = 8'h07;

    // one word through a CRC-8 register, MSB first
    function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] crc,
                                                   input logic [WORD_W-1:0] w,
                                                   input logic [WORD_W-1:0] poly);
        logic [WORD_W-1:0] c;
        logic fb;
        c = crc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[WORD_W-1] ^ w[i];
            c  = {c[WORD_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int            STAGES  = 2,
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    assign pipe_d[0] = din;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign pipe_d[g] = pipe_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sel_n,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int BIT_CW = $clog2(WORD_W);

    typedef struct packed {
        logic              sck_prev;
        logic [WORD_W-1:0] bits;
        logic [BIT_CW-1:0] cnt;
    } sh_t;

    sh_t st_d, st_q;
    logic rise, active, last;

    always_comb begin
        st_d          = st_q;
        rise          = sck & ~st_q.sck_prev;
        active        = en & ~sel_n;
        last          = (st_q.cnt == BIT_CW'(WORD_W - 1));
        st_d.sck_prev = sck;
        word          = {st_q.bits[WORD_W-2:0], sdi};
        word_done     = active & rise & last;
        if (!active) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.bits = word;
            st_d.cnt  = last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sck_prev: 1'b1, bits: '0, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_rx_crcu.sv
module spi_rx_crcu
    import spi_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] poly,
    input  logic [CNT_W-1:0]  limit,
    output logic              mismatch
);
    typedef struct packed {
        logic [WORD_W-1:0] crc;
        logic [CNT_W-1:0]  n;
    } cu_t;

    cu_t st_d, st_q;
    logic is_crc;

    always_comb begin
        st_d     = st_q;
        is_crc   = (st_q.n == limit);
        mismatch = active & word_done & is_crc & (word != st_q.crc);
        if (!active) begin
            st_d = '0;
        end else if (word_done) begin
            if (is_crc) begin
                st_d = '0;
            end else begin
                st_d.crc = crc_step(st_q.crc, word, poly);
                st_d.n   = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_rx_crc.sv
module spi_rx_crc
    import spi_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic        ss_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic [7:0]  dma_data,
    output logic        rxne,
    output logic        ovr,
    output logic        crc_err
);
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              rxne;
        logic              ovr;
        logic              cerr;
        logic [WORD_W-1:0] poly;
        logic [2:0]        ctrl;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]        pins_s;
    logic              word_done, mismatch, rd_hit, crc_on;
    logic [WORD_W-1:0] word;

    spi_rx_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b101)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n, mosi, sclk}),
        .dout (pins_s)
    );

    spi_rx_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (r_q.ctrl[CTL_EN]),
        .sck      (pins_s[0]),
        .sdi      (pins_s[1]),
        .sel_n    (pins_s[2]),
        .word_done(word_done),
        .word     (word)
    );

    assign crc_on = r_q.ctrl[CTL_EN] & r_q.ctrl[CTL_DMA] & r_q.ctrl[CTL_CRC];

    spi_rx_crcu #(.CNT_W(CNT_W)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (crc_on),
        .word_done(word_done),
        .word     (word),
        .poly     (r_q.poly),
        .limit    (r_q.cnt),
        .mismatch (mismatch)
    );

    assign dma_req  = r_q.rxne & r_q.ctrl[CTL_DMA];
    assign dma_data = r_q.data;
    assign rxne     = r_q.rxne;
    assign ovr      = r_q.ovr;
    assign crc_err  = r_q.cerr;
    assign rd_hit   = (reg_rd && reg_addr == ADR_DATA) || (dma_ack && dma_req);

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                ADR_STAT: begin
                    if (!reg_wdata[ST_OVR])  r_d.ovr  = 1'b0;
                    if (!reg_wdata[ST_CERR]) r_d.cerr = 1'b0;
                end
                ADR_POLY: r_d.poly = reg_wdata;
                ADR_CTRL: r_d.ctrl = reg_wdata[2:0];
                ADR_CNT:  r_d.cnt  = CNT_W'(reg_wdata);
                default: ;
            endcase
        end
        if (rd_hit) r_d.rxne = 1'b0;
        if (word_done) begin
            if (r_q.rxne && !rd_hit) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data = word;
                r_d.rxne = 1'b1;
            end
        end
        if (mismatch) r_d.cerr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{data: '0, rxne: 1'b0, ovr: 1'b0, cerr: 1'b0,
                             poly: POLY_RST, ctrl: '0, cnt: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            ADR_DATA: reg_rdata = r_q.data;
            ADR_STAT: reg_rdata = {5'd0, r_q.cerr, r_q.ovr, r_q.rxne};
            ADR_POLY: reg_rdata = r_q.poly;
            ADR_CTRL: reg_rdata = {5'd0, r_q.ctrl};
            ADR_CNT:  reg_rdata = 8'(r_q.cnt);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_rx_chk.sv
module spi_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_done,
    input logic       rd_hit,
    input logic       mismatch,
    input logic       rxne,
    input logic       ovr,
    input logic       crc_err,
    input logic       dma_req,
    input logic [7:0] dma_data,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata
);
    logic cerr_clr;
    assign cerr_clr = reg_wr && (reg_addr == 3'd1) && (reg_wdata[2] == 1'b0);

    // R2
    word_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && !rxne |=> rxne);

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && !word_done |=> !rxne);

    // R5
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && rxne && !rd_hit |=> ovr && $stable(dma_data));

    // R4
    req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> rxne);

    // R8
    mismatch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> crc_err);

    // R8
    cerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err && !cerr_clr |=> crc_err);
endmodule

bind spi_rx_crc spi_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_done(word_done),
    .rd_hit   (rd_hit),
    .mismatch (mismatch),
    .rxne     (rxne),
    .ovr      (ovr),
    .crc_err  (crc_err),
    .dma_req  (dma_req),
    .dma_data (dma_data),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/spi_rx_crc_bench.sv
module spi_rx_crc_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1, mosi = 1'b0, ss_n = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, dma_ack = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, dma_data;
    logic       dma_req, rxne, ovr, crc_err;

    int total = 0, bad = 0, pops = 0;
    bit done = 0, mon_on = 0;
    logic [7:0] expq[$];
    logic [7:0] acc = '0, poly_m = 8'h07, rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rx_crc u_spi_rx_crc (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = (a == 3'd0); reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    function automatic logic [7:0] model_crc(input logic [7:0] c, input logic [7:0] w);
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ w[i]) c = {c[6:0], 1'b0} ^ poly_m;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    task automatic send_bits(input logic [7:0] b, input int n, input bit push);
        if (push) expq.push_back(b);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); sclk = 0; mosi = b[i];
            repeat (4) @(negedge clk);
            sclk = 1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic sel(input logic v);
        repeat (4) @(negedge clk); ss_n = v; repeat (4) @(negedge clk);
    endtask

    task automatic data_word(input logic [7:0] b);
        send_bits(b, 8, 1);
        acc = model_crc(acc, b);
    endtask

    task automatic crc_word(input logic [7:0] flip);
        send_bits(acc ^ flip, 8, 1);
        acc = '0;
    endtask

    task automatic drain(input string tag, input int exp_pops);
        repeat (30) @(negedge clk);
        check(expq.size() == 0 && pops == exp_pops, tag, pops, exp_pops);
        pops = 0;
    endtask

    // scoreboard monitor: acts as DMA and compares each delivered word
    initial begin
        forever begin
            @(negedge clk);
            if (dma_ack) dma_ack = 0;
            else if (mon_on && dma_req) begin
                if (expq.size() == 0) check(0, "R4 unexpected dma word", dma_data, 0);
                else begin
                    rv = expq.pop_front();
                    check(dma_data == rv, "R4/R6 dma word", dma_data, rv);
                end
                pops++;
                dma_ack = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11
        check(!rxne && !ovr && !crc_err && !dma_req, "R11 flags", {rxne, ovr, crc_err, dma_req}, 0);
        rd(3'd2, v); check(v == 8'h07, "R11 poly reset", v, 8'h07);
        rd(3'd3, v); check(v == 8'h00, "R11 ctrl reset", v, 0);

        // R1 disabled: nothing sampled
        sel(0); send_bits(8'h5A, 8, 0); sel(1);
        check(!rxne, "R1 disabled", rxne, 0);

        wr(3'd3, 8'h01);
        sel(0); send_bits(8'hA5, 8, 0); repeat (8) @(negedge clk);
        check(rxne, "R2 rxne set", rxne, 1);
        check(!dma_req, "R4 no req outside dma mode", dma_req, 0);
        rd(3'd0, v); check(v == 8'hA5, "R1 msb first", v, 8'hA5);
        check(!rxne, "R3 read clears", rxne, 1'b0);
        sel(1);

        // R1 aborted partial word
        sel(0); send_bits(8'hF0, 3, 0); sel(1);
        sel(0); send_bits(8'h3C, 8, 0); repeat (8) @(negedge clk);
        rd(3'd0, v); check(v == 8'h3C, "R1 partial dropped", v, 8'h3C);

        // R5 overrun
        send_bits(8'h11, 8, 0); send_bits(8'h22, 8, 0); repeat (8) @(negedge clk);
        check(ovr, "R5 ovr set", ovr, 1);
        rd(3'd0, v); check(v == 8'h11, "R5 earlier kept", v, 8'h11);
        wr(3'd1, 8'h04);
        check(!ovr, "R5 ovr cleared", ovr, 0);
        sel(1);

        // DMA + CRC, three data words
        mon_on = 1;
        wr(3'd4, 8'd3); wr(3'd3, 8'h07);
        sel(0);
        data_word(8'hA1); data_word(8'hA2); data_word(8'hA3); crc_word(8'h00);
        drain("R6 crc word delivered", 4);
        check(!crc_err, "R7 good frame", crc_err, 0);

        data_word(8'h10); data_word(8'h20); data_word(8'h30); crc_word(8'h01);
        drain("R6 bad frame words", 4);
        check(crc_err, "R8 mismatch flagged", crc_err, 1);

        data_word(8'h44); data_word(8'h55); data_word(8'h66); crc_word(8'h00);
        drain("R9 next frame words", 4);
        check(crc_err, "R8 sticky", crc_err, 1);
        wr(3'd1, 8'h02);
        check(!crc_err, "R8 cleared by zero write", crc_err, 0);
        sel(1);

        // R7 other polynomial, R9 back to back
        poly_m = 8'h31; wr(3'd2, 8'h31); wr(3'd4, 8'd2);
        sel(0);
        data_word(8'h5A); data_word(8'hC3); crc_word(8'h00);
        data_word(8'h00); data_word(8'hFF); crc_word(8'h00);
        drain("R9 two frames", 6);
        check(!crc_err, "R7/R9 poly 0x31 frames", crc_err, 0);
        sel(1);

        // R10 dma without crc
        wr(3'd3, 8'h03);
        sel(0);
        send_bits(8'h01, 8, 1); send_bits(8'h02, 8, 1);
        send_bits(8'h03, 8, 1); send_bits(8'h99, 8, 1);
        drain("R10 all words data", 4);
        check(!crc_err, "R10 no crc error", crc_err, 0);
        sel(1);
        check(!rxne && !dma_req, "R3 idle after drain", {rxne, dma_req}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule